// File: doc/BRIEF.md
# Nested-Width Vector/Scalar Register File

This block holds 32 registers that software can address through three namespaces of different widths: a 64-bit scalar floating-point namespace, a 128-bit short-vector namespace and a 256-bit long-vector namespace. There is only one physical array. Register k in a narrower namespace is the low-order slice of register k in every wider one. A scalar write to register 7 is therefore visible in the low 64 bits of short-vector register 7 and of long-vector register 7.

The block has one write port and two read ports. Each port carries its own index and its own width select. Reads are combinational and return a 256-bit bus: narrow reads arrive zero-extended. A write commits on the rising clock edge and touches only the bits its width covers. A read that targets the register being written in the same cycle sees the merged new value.

Top module: `vreg_file_alias`

## Requirements
- R1: There are 32 entries, indexed 0 to 31. Every index is reachable through every width select, and every index obeys the same aliasing.
- R2: A write with width select 2 (256-bit) replaces all 256 bits of the indexed entry. A read on the following cycle returns that value.
- R3: A write with width select 0 changes only bits 63:0 of the entry. A write with width select 1 changes only bits 127:0. The remaining bits keep their previous contents, and the bits of the write data above the selected width are ignored.
- R4: A read with width select 0 returns bits 63:0 of the entry with bits 255:64 zero. A read with width select 1 returns bits 127:0 with bits 255:128 zero. A read with width select 2 returns the full entry.
- R5: The two read ports are independent and combinational. In the same cycle, each port returns the data for its own index and width select.
- R6: When a read index equals the write index while the write is enabled, the read returns the stored entry with the bits covered by the write width replaced by the new write data. The width select of the read is then applied.
- R7: An active-low asynchronous reset clears every entry to zero.
- R8: A write with width select 3, or with the write enable low, changes no entry and affects no read.
- R9: A read with width select 3 returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write index |
| wr_view_i | input | 2 | Write width select (0: 64, 1: 128, 2: 256, 3: no-op) |
| wr_data_i | input | 256 | Write data, low-aligned |
| rd0_idx_i | input | 5 | Read port 0 index |
| rd0_view_i | input | 2 | Read port 0 width select |
| rd0_data_o | output | 256 | Read port 0 data, zero-extended |
| rd1_idx_i | input | 5 | Read port 1 index |
| rd1_view_i | input | 2 | Read port 1 width select |
| rd1_data_o | output | 256 | Read port 1 data, zero-extended |

## Verification
Narrow writes use random data that has garbage above the selected width. A design that ignored the width would leak those bits into the entry, and a design that zeroed the upper part would destroy the high lanes; a later 256-bit read exposes either fault. Same-cycle read-after-write is exercised at every combination of write and read width. A missing bypass would return stale data, and a bypass that copied the whole write word would return corrupted upper bits. Writes with width select 3, writes with the enable low and reads with width select 3 are also targeted, along with long random runs on both ports, so that a mis-decoded select or a crossed port shows up at the outputs.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef enum logic [1:0] {
    VIEW_FP  = 2'd0,
    VIEW_SV  = 2'd1,
    VIEW_LV  = 2'd2,
    VIEW_NOP = 2'd3
  } view_e;
endpackage

// File: rtl/vrf_view_mask.sv
module vrf_view_mask #(
  parameter int LV_W = 256,
  parameter int SV_W = 128,
  parameter int FP_W = 64
) (
  input  logic            en_i,
  input  logic [1:0]      view_i,
  output logic [LV_W-1:0] mask_o
);
  import vrf_pkg::*;

  always_comb begin
    mask_o = '0;
    if (en_i) begin
      unique case (view_e'(view_i))
        VIEW_FP:  mask_o = LV_W'({FP_W{1'b1}});
        VIEW_SV:  mask_o = LV_W'({SV_W{1'b1}});
        VIEW_LV:  mask_o = '1;
        default:  mask_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vrf_storage.sv
module vrf_storage #(
  parameter int NUM_REGS = 32,
  parameter int LV_W     = 256,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [LV_W-1:0]                wr_mask_i,
  input  logic [LV_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][LV_W-1:0]  mem_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_o[g] <= '0;
      end else if (wr_idx_i == IDX_W'(g)) begin
        // masked merge: bits outside the view keep their value
        mem_o[g] <= (mem_o[g] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
      end
    end
  end
endmodule

// File: rtl/vrf_rd_port.sv
module vrf_rd_port #(
  parameter int NUM_REGS = 32,
  parameter int LV_W     = 256,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][LV_W-1:0] mem_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  input  logic [LV_W-1:0]               rd_mask_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [LV_W-1:0]               wr_mask_i,
  input  logic [LV_W-1:0]               wr_data_i,
  output logic [LV_W-1:0]               rd_data_o
);
  logic [LV_W-1:0] raw;

  always_comb begin
    raw = mem_i[rd_idx_i];
    if (rd_idx_i == wr_idx_i) begin
      raw = (raw & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
    rd_data_o = raw & rd_mask_i;
  end
endmodule

// File: rtl/vreg_file_alias.sv
module vreg_file_alias #(
  parameter int NUM_REGS = 32,
  parameter int LV_W     = 256,
  parameter int SV_W     = 128,
  parameter int FP_W     = 64,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_view_i,
  input  logic [LV_W-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd0_idx_i,
  input  logic [1:0]       rd0_view_i,
  output logic [LV_W-1:0]  rd0_data_o,
  input  logic [IDX_W-1:0] rd1_idx_i,
  input  logic [1:0]       rd1_view_i,
  output logic [LV_W-1:0]  rd1_data_o
);
  localparam int NUM_RD = 2;

  logic [NUM_REGS-1:0][LV_W-1:0] mem_q;
  logic [LV_W-1:0]               wr_mask;
  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [NUM_RD-1:0][1:0]        rd_view;
  logic [NUM_RD-1:0][LV_W-1:0]   rd_data;

  assign rd_idx  = {rd1_idx_i, rd0_idx_i};
  assign rd_view = {rd1_view_i, rd0_view_i};
  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];

  vrf_view_mask #(.LV_W(LV_W), .SV_W(SV_W), .FP_W(FP_W)) u_wr_mask (
    .en_i   (wr_en_i),
    .view_i (wr_view_i),
    .mask_o (wr_mask)
  );

  vrf_storage #(.NUM_REGS(NUM_REGS), .LV_W(LV_W), .IDX_W(IDX_W)) u_storage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_idx_i  (wr_idx_i),
    .wr_mask_i (wr_mask),
    .wr_data_i (wr_data_i),
    .mem_o     (mem_q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [LV_W-1:0] rd_mask;

    vrf_view_mask #(.LV_W(LV_W), .SV_W(SV_W), .FP_W(FP_W)) u_rd_mask (
      .en_i   (1'b1),
      .view_i (rd_view[p]),
      .mask_o (rd_mask)
    );

    vrf_rd_port #(.NUM_REGS(NUM_REGS), .LV_W(LV_W), .IDX_W(IDX_W)) u_port (
      .mem_i     (mem_q),
      .rd_idx_i  (rd_idx[p]),
      .rd_mask_i (rd_mask),
      .wr_idx_i  (wr_idx_i),
      .wr_mask_i (wr_mask),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data[p])
    );
  end
endmodule

// File: rtl/vrf_alias_chk.sv
module vrf_alias_chk #(
  parameter int NUM_REGS = 32,
  parameter int LV_W     = 256,
  parameter int SV_W     = 128,
  parameter int FP_W     = 64,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [IDX_W-1:0]              wr_idx_i,
  input logic [1:0]                    wr_view_i,
  input logic [LV_W-1:0]               wr_data_i,
  input logic [IDX_W-1:0]              rd0_idx_i,
  input logic [1:0]                    rd0_view_i,
  input logic [LV_W-1:0]               rd0_data_o,
  input logic [IDX_W-1:0]              rd1_idx_i,
  input logic [1:0]                    rd1_view_i,
  input logic [LV_W-1:0]               rd1_data_o,
  input logic [NUM_REGS-1:0][LV_W-1:0] mem_q
);
  p_full_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_view_i == 2'd2 |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i));

  p_keep_hi_fp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_view_i == 2'd0 |=>
      mem_q[$past(wr_idx_i)][LV_W-1:FP_W] == $past(mem_q[wr_idx_i][LV_W-1:FP_W]));

  p_keep_hi_sv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_view_i == 2'd1 |=>
      mem_q[$past(wr_idx_i)][LV_W-1:SV_W] == $past(mem_q[wr_idx_i][LV_W-1:SV_W]));

  p_zext_fp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd0_view_i == 2'd0 |-> rd0_data_o[LV_W-1:FP_W] == '0);

  p_zext_sv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd1_view_i == 2'd1 |-> rd1_data_o[LV_W-1:SV_W] == '0);

  p_port_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd0_idx_i == rd1_idx_i && rd0_view_i == rd1_view_i |-> rd0_data_o == rd1_data_o);

  p_nop_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i || wr_view_i == 2'd3 |=> mem_q == $past(mem_q));

  p_nop_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd0_view_i == 2'd3 |-> rd0_data_o == '0);
endmodule

bind vreg_file_alias vrf_alias_chk #(
  .NUM_REGS(NUM_REGS), .LV_W(LV_W), .SV_W(SV_W), .FP_W(FP_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_view_i  (wr_view_i),
  .wr_data_i  (wr_data_i),
  .rd0_idx_i  (rd0_idx_i),
  .rd0_view_i (rd0_view_i),
  .rd0_data_o (rd0_data_o),
  .rd1_idx_i  (rd1_idx_i),
  .rd1_view_i (rd1_view_i),
  .rd1_data_o (rd1_data_o),
  .mem_q      (mem_q)
);

// File: tb/tb_vreg_file_alias.sv
module tb_vreg_file_alias;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;
  localparam int W  = 256;

  typedef struct {
    bit         chk;
    logic [W-1:0] e0;
    logic [W-1:0] e1;
    string      tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_idx = '0;
  logic [1:0]   wr_view = '0;
  logic [W-1:0] wr_data = '0;
  logic [4:0]   r0_idx = '0, r1_idx = '0;
  logic [1:0]   r0_view = '0, r1_view = '0;
  logic [W-1:0] r0_data, r1_data;

  logic [W-1:0] model [NR];
  item_t        q [$];
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vreg_file_alias dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_view_i(wr_view), .wr_data_i(wr_data),
    .rd0_idx_i(r0_idx), .rd0_view_i(r0_view), .rd0_data_o(r0_data),
    .rd1_idx_i(r1_idx), .rd1_view_i(r1_view), .rd1_data_o(r1_data)
  );

  function automatic logic [W-1:0] vmask(logic [1:0] v);
    case (v)
      2'd0:    return W'({64{1'b1}});
      2'd1:    return W'({128{1'b1}});
      2'd2:    return '1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] r;
    for (int i = 0; i < W/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [W-1:0] expect_rd(logic [4:0] i, logic [1:0] v);
    logic [W-1:0] b, m;
    b = model[i];
    m = wr_en ? vmask(wr_view) : '0;
    if (wr_idx == i) b = (b & ~m) | (wr_data & m);
    return b & vmask(v);
  endfunction

  task automatic step(bit we, logic [4:0] wi, logic [1:0] wv, logic [W-1:0] wd,
                      logic [4:0] a, logic [1:0] av, logic [4:0] b, logic [1:0] bv,
                      bit chk, string tag);
    item_t it;
    logic [W-1:0] m;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_view = wv; wr_data = wd;
    r0_idx = a; r0_view = av; r1_idx = b; r1_view = bv;
    it.chk = chk; it.tag = tag;
    it.e0 = expect_rd(a, av);
    it.e1 = expect_rd(b, bv);
    q.push_back(it);
    m = we ? vmask(wv) : '0;
    model[wi] = (model[wi] & ~m) | (wd & m);
  endtask

  task automatic rd(logic [4:0] a, logic [1:0] av, logic [4:0] b, logic [1:0] bv, string tag);
    step(1'b0, '0, 2'd2, '0, a, av, b, bv, 1'b1, tag);
  endtask

  task automatic wr(logic [4:0] i, logic [1:0] v, logic [W-1:0] d, string tag);
    step(1'b1, i, v, d, i, 2'd2, i, v, 1'b1, tag);
  endtask

  // monitor: pops one expected item per cycle, compares mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chk) begin
          n_chk += 2;
          if (r0_data !== it.e0) begin
            n_fail++;
            $display("FAIL %s port0 actual=%h expected=%h", it.tag, r0_data, it.e0);
          end
          if (r1_data !== it.e1) begin
            n_fail++;
            $display("FAIL %s port1 actual=%h expected=%h", it.tag, r1_data, it.e1);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R7: reset state, every index through both ports
    for (int i = 0; i < NR; i++) rd(5'(i), 2'd2, 5'(31 - i), 2'd2, "R7 reset zero");

    // R2: full write then read next cycle
    wr(5'd5, 2'd2, rnd256(), "R2 full write bypass");
    rd(5'd5, 2'd2, 5'd5, 2'd2, "R2 full read");
    // R4: narrow reads zero-extend
    rd(5'd5, 2'd0, 5'd5, 2'd1, "R4 zext narrow read");
    // R3: 64-bit write with garbage above, upper bits kept
    wr(5'd5, 2'd0, rnd256(), "R3 fp write");
    rd(5'd5, 2'd2, 5'd5, 2'd1, "R3 upper kept after fp write");
    // R3: 128-bit write on the top index (R1 aliasing at 31)
    wr(5'd31, 2'd2, rnd256(), "R1 top index full write");
    wr(5'd31, 2'd1, rnd256(), "R3 sv write");
    rd(5'd31, 2'd2, 5'd31, 2'd0, "R1 R3 aliasing idx31");
    // R6: same-cycle bypass at each write/read width pairing
    for (int wv = 0; wv < 3; wv++)
      for (int rv = 0; rv < 3; rv++)
        step(1'b1, 5'd9, 2'(wv), rnd256(), 5'd9, 2'(rv), 5'd10, 2'd2, 1'b1, "R6 bypass");
    // R6: different index, no bypass
    step(1'b1, 5'd11, 2'd2, rnd256(), 5'd12, 2'd2, 5'd9, 2'd2, 1'b1, "R6 no bypass other idx");
    // R8: view 3 write and enable-low write leave entry intact
    step(1'b1, 5'd5, 2'd3, '1, 5'd5, 2'd2, 5'd5, 2'd0, 1'b1, "R8 nop view write");
    rd(5'd5, 2'd2, 5'd5, 2'd1, "R8 after nop view write");
    step(1'b0, 5'd5, 2'd2, '1, 5'd5, 2'd2, 5'd5, 2'd2, 1'b1, "R8 write disabled");
    rd(5'd5, 2'd2, 5'd5, 2'd2, "R8 after disabled write");
    // R9: read select 3
    rd(5'd5, 2'd3, 5'd31, 2'd3, "R9 nop view read");
    // R1 R5: every index, distinct data, both ports different widths
    for (int i = 0; i < NR; i++) begin
      d = rnd256();
      step(1'b1, 5'(i), 2'd2, d, 5'(i), 2'd2, 5'((i + 7) % NR), 2'd1, 1'b1, "R1 sweep write");
    end
    for (int i = 0; i < NR; i++)
      rd(5'(i), 2'(i % 3), 5'(NR - 1 - i), 2'((i + 1) % 3), "R5 independent ports");
    // mixed random traffic
    for (int k = 0; k < 600; k++)
      step(1'($urandom), 5'($urandom), 2'($urandom), rnd256(),
           5'($urandom), 2'($urandom), 5'($urandom), 2'($urandom), 1'b1, "R5 R6 random");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule